// File: doc/BRIEF.md
# MDIO Serial Management Slave

This block is the slave end of a two-wire serial management link of the clause-22 kind. A station manager toggles a management clock (`mdc`) and shifts frames on a data line. The slave takes `mdc` and the incoming data into the system clock domain. It finds a preamble of ones and decodes the start, opcode, PHY address and register number fields. It then turns the frame into either a one-cycle write strobe or a register fetch, presented on a simple PHY register port.

On a read to its own address, the slave fetches the register at the end of the turnaround. It then shifts the 16-bit value out MSB first and updates its data output after every falling `mdc` edge. On a write, it collects 16 bits on rising edges and commits them only once the last bit has arrived. A read or write to a different address leaves the line released. A pulled-up line then reads as all ones. After the data phase the slave waits for a fresh preamble.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: After reset, mdio_oe is 0, mdio_out is 1, reg_we is 0 and start_err is 0.
- R2: A frame is accepted only when at least PRE_MIN (default 32) consecutive ones have been sampled on rising mdc edges and a 0 is then sampled. A zero after fewer ones restarts the preamble count, and the frame that follows has no effect.
- R3: After the start 0, the slave samples on successive rising mdc edges the second start bit, a 2-bit opcode, a 5-bit PHY address and a 5-bit register number, each MSB first. It then samples two turnaround bits. reg_num presents the captured register number.
- R4: For opcode 01 (write) to the matching address, 16 data bits are sampled MSB first on rising edges. reg_we pulses for exactly one clock, with reg_wdata and reg_num valid, only after the sixteenth bit. With 15 bits there is no pulse.
- R5: For opcode 10 (read) to the matching address, reg_rdata is captured at the second turnaround rising edge. Bit 15 down to bit 0 then appear on mdio_out, one bit after each of the next 16 falling mdc edges, so a manager sampling on rising edges reads the register value.
- R6: A frame whose PHY address differs from phy_addr produces no write strobe and no drive. A read then returns 0xFFFF on the pulled-up line.
- R7: mdio_oe is 1 only during the data phase of a matching read. At all other times it is 0, and mdio_out is then 1.
- R8: If the second start bit is sampled as 0, start_err goes to 1 and the frame is still decoded. The next frame with a second start bit of 1 clears start_err.
- R9: Opcodes 00 and 11 cause neither a write nor a drive. Their 16 data bits are consumed and the slave then waits for a preamble again.
- R10: After the sixteenth data bit, the slave again requires a full preamble. A frame sent straight after another, with no preamble, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc | input | 1 | Management clock from the station manager (asynchronous) |
| mdio_in | input | 1 | Management data line as seen by the slave |
| phy_addr | input | 5 | PHY address this slave answers to |
| reg_rdata | input | 16 | Register value for reg_num, captured at the end of turnaround |
| mdio_out | output | 1 | Data driven onto the line; 1 when not driving |
| mdio_oe | output | 1 | Output enable for mdio_out |
| reg_num | output | 5 | Register number of the current or last frame |
| reg_wdata | output | 16 | Write data, valid while reg_we is 1 |
| reg_we | output | 1 | One-cycle register write strobe |
| start_err | output | 1 | Second start bit of the last frame was 0 |

## Verification
An mdc or data change reaches the decoder two clocks after it is driven, and the decoder acts on the third clock. So reg_we rises three clocks after the sixteenth rising mdc edge of a write, and mdio_out moves three clocks after each falling edge of a read. The bench holds each mdc half period for five clocks. It reads the line at the end of each low half, which is after the new read bit has settled. It counts write strobes on the falling system-clock edge and checks them a few clocks after the frame's last bit. The start_err and output-enable checks are made only after a frame is complete.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;

  localparam int DATA_W = 16;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int OP_W   = 2;
  localparam int CNT_W  = $clog2(DATA_W);

  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
  localparam logic [OP_W-1:0] OP_READ  = 2'b10;

  typedef enum logic [2:0] {
    PH_PRE,
    PH_START2,
    PH_OP,
    PH_PHY,
    PH_REG,
    PH_TURN,
    PH_DATA
  } phase_e;

  // index of the last bit of a phase (bit count minus one)
  function automatic logic [CNT_W-1:0] phase_last(input phase_e ph);
    case (ph)
      PH_START2: return CNT_W'(0);
      PH_OP:     return CNT_W'(OP_W - 1);
      PH_PHY:    return CNT_W'(PHY_W - 1);
      PH_REG:    return CNT_W'(REG_W - 1);
      PH_TURN:   return CNT_W'(1);
      PH_DATA:   return CNT_W'(DATA_W - 1);
      default:   return CNT_W'(0);
    endcase
  endfunction

  function automatic phase_e next_phase(input phase_e ph);
    case (ph)
      PH_START2: return PH_OP;
      PH_OP:     return PH_PHY;
      PH_PHY:    return PH_REG;
      PH_REG:    return PH_TURN;
      PH_TURN:   return PH_DATA;
      default:   return PH_PRE;
    endcase
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return op == OP_READ;
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return op == OP_WRITE;
  endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic mdc_rise,
  output logic mdc_fall,
  output logic mdio_bit
);

  logic [STAGES:0]   mdc_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= '0;
    else        mdc_q <= {mdc_q[STAGES-1:0], mdc};
  end

  // data chain is one stage shorter: its last stage lines up with mdc_q[STAGES-1]
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dat_q <= 1'b1;
        else        dat_q <= mdio_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dat_q <= '1;
        else        dat_q <= {dat_q[STAGES-2:0], mdio_in};
      end
    end
  endgenerate

  assign mdc_rise = mdc_q[STAGES-1] & ~mdc_q[STAGES];
  assign mdc_fall = ~mdc_q[STAGES-1] & mdc_q[STAGES];
  assign mdio_bit = dat_q[STAGES-1];

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_slave_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc_rise,
  input  logic              mdc_fall,
  input  logic              mdio_bit,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [REG_W-1:0]  reg_num,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              start_err
);

  localparam int PRE_W = $clog2(PRE_MIN + 1);

  phase_e            st;
  logic [PRE_W-1:0]  pre_cnt;
  logic [CNT_W-1:0]  bit_cnt;
  logic [OP_W-1:0]   op_q;
  logic [PHY_W-1:0]  phy_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] sh;
  logic              drive;
  logic              out_bit;

  // named internal events
  logic pre_ok, at_last, frame_start, ta_done, data_done;
  logic addr_hit, rd_go, wr_commit, launch;

  always_comb begin
    pre_ok      = pre_cnt >= PRE_W'(PRE_MIN);
    at_last     = bit_cnt == phase_last(st);
    frame_start = mdc_rise && (st == PH_PRE) && !mdio_bit && pre_ok;
    ta_done     = mdc_rise && (st == PH_TURN) && at_last;
    data_done   = mdc_rise && (st == PH_DATA) && at_last;
    addr_hit    = phy_q == phy_addr;
    rd_go       = ta_done && op_is_read(op_q) && addr_hit;
    wr_commit   = data_done && !drive && op_is_write(op_q) && addr_hit;
    launch      = mdc_fall && drive && (st == PH_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_PRE;
      pre_cnt   <= '0;
      bit_cnt   <= '0;
      op_q      <= '0;
      phy_q     <= '0;
      reg_q     <= '0;
      sh        <= '0;
      drive     <= 1'b0;
      out_bit   <= 1'b1;
      reg_we    <= 1'b0;
      start_err <= 1'b0;
    end else begin
      reg_we <= wr_commit;
      if (mdc_rise) begin
        if (st == PH_PRE) begin
          if (frame_start) begin
            st      <= PH_START2;
            pre_cnt <= '0;
            bit_cnt <= '0;
          end else if (mdio_bit) begin
            if (!pre_ok) pre_cnt <= pre_cnt + 1'b1;
          end else begin
            pre_cnt <= '0;
          end
        end else begin
          if (at_last) begin
            st      <= next_phase(st);
            bit_cnt <= '0;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
          case (st)
            PH_START2: start_err <= !mdio_bit;
            PH_OP:     op_q  <= {op_q[OP_W-2:0], mdio_bit};
            PH_PHY:    phy_q <= {phy_q[PHY_W-2:0], mdio_bit};
            PH_REG:    reg_q <= {reg_q[REG_W-2:0], mdio_bit};
            PH_TURN: begin
              if (rd_go) begin
                drive   <= 1'b1;
                sh      <= reg_rdata;
                out_bit <= reg_rdata[DATA_W-1];
              end
            end
            PH_DATA: begin
              if (!drive) sh <= {sh[DATA_W-2:0], mdio_bit};
              if (at_last) begin
                drive   <= 1'b0;
                out_bit <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      if (launch) begin
        out_bit <= sh[DATA_W-1];
        sh      <= {sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign mdio_out  = out_bit;
  assign mdio_oe   = drive;
  assign reg_num   = reg_q;
  assign reg_wdata = sh;

  AST_SHORT_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_PRE && mdc_rise && !mdio_bit && !pre_ok) |=> st == PH_PRE); // R2
  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R4
  AST_WE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(op_is_write(op_q) && addr_hit && st == PH_DATA)); // R4
  AST_OE_HOLDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && !mdc_fall) |=> (!mdio_oe || $stable(mdio_out))); // R5
  AST_OE_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> (st == PH_DATA && op_is_read(op_q))); // R7
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> mdio_out); // R7
  AST_NO_WE_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && mdio_oe)); // R6

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_MIN     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mdc,
  input  logic              mdio_in,
  input  logic [PHY_W-1:0]  phy_addr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              mdio_out,
  output logic              mdio_oe,
  output logic [REG_W-1:0]  reg_num,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              start_err
);

  logic mdc_rise, mdc_fall, mdio_bit;

  mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .mdc_rise (mdc_rise),
    .mdc_fall (mdc_fall),
    .mdio_bit (mdio_bit)
  );

  mdio_frame_ctrl #(.PRE_MIN(PRE_MIN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_rise  (mdc_rise),
    .mdc_fall  (mdc_fall),
    .mdio_bit  (mdio_bit),
    .phy_addr  (phy_addr),
    .reg_rdata (reg_rdata),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .reg_num   (reg_num),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .start_err (start_err)
  );

endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

  localparam int H = 5;  // clocks per mdc half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        mdio_drv = 1'b1;
  logic [4:0]  phy_addr = 5'h0B;
  logic [15:0] reg_rdata;
  logic        mdio_out, mdio_oe, reg_we, start_err;
  logic [4:0]  reg_num;
  logic [15:0] reg_wdata;

  logic [15:0] phy_mem [32];
  int          vectors = 0;
  int          errors  = 0;
  int          we_cnt  = 0;
  int          oe_cnt  = 0;
  logic [4:0]  last_num;
  logic [15:0] last_wd;
  bit          done = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt_slave uut (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_in(mdio_drv),
    .phy_addr(phy_addr), .reg_rdata(reg_rdata), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .reg_num(reg_num), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .start_err(start_err)
  );

  // bench PHY register file and strobe monitor
  assign reg_rdata = phy_mem[reg_num];

  always @(negedge clk) begin
    if (reg_we) begin
      we_cnt++;
      last_num = reg_num;
      last_wd  = reg_wdata;
      phy_mem[reg_num] = reg_wdata;
    end
    if (mdio_oe) oe_cnt++;
  end

  function automatic logic [15:0] pat(input int r);
    return 16'((r * 4951) ^ 49317 ^ (r << 11));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic mbit(input logic b);
    @(negedge clk);
    mdc = 1'b0; mdio_drv = b;
    repeat (H) @(negedge clk);
    mdc = 1'b1;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic rbit(output logic b);
    @(negedge clk);
    mdc = 1'b0; mdio_drv = 1'b1;
    repeat (H) @(negedge clk);
    b = mdio_oe ? mdio_out : 1'b1;  // pulled-up line
    mdc = 1'b1;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) mbit(1'b1);
  endtask

  task automatic header(input logic st2, input logic [1:0] op,
                        input logic [4:0] pa, input logic [4:0] rg);
    mbit(1'b0); mbit(st2);
    for (int i = 1; i >= 0; i--) mbit(op[i]);
    for (int i = 4; i >= 0; i--) mbit(pa[i]);
    for (int i = 4; i >= 0; i--) mbit(rg[i]);
  endtask

  task automatic wr_frame(input int npre, input logic st2, input logic [1:0] op,
                          input logic [4:0] pa, input logic [4:0] rg, input logic [15:0] d);
    preamble(npre);
    header(st2, op, pa, rg);
    mbit(1'b1); mbit(1'b0);
    for (int i = 15; i >= 0; i--) mbit(d[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic rd_frame(input logic [4:0] pa, input logic [4:0] rg, output logic [15:0] d);
    logic b;
    preamble(32);
    header(1'b1, 2'b10, pa, rg);
    mbit(1'b1); mbit(1'b1);
    for (int i = 15; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int w0, o0;
    for (int i = 0; i < 32; i++) phy_mem[i] = 16'h0000;
    repeat (4) @(negedge clk);
    chk("R1 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R1 out", {31'd0, mdio_out}, 32'd1);
    chk("R1 we", {31'd0, reg_we}, 32'd0);
    chk("R1 start_err", {31'd0, start_err}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4/R3 write sweep over every register number
    for (int r = 0; r < 32; r++) begin
      w0 = we_cnt; o0 = oe_cnt;
      wr_frame(32, 1'b1, 2'b01, phy_addr, 5'(r), pat(r));
      chk("R4 write strobe count", we_cnt, w0 + 1);
      chk("R3 reg_num", {27'd0, last_num}, r);
      chk("R4 write data", {16'd0, last_wd}, {16'd0, pat(r)});
      chk("R7 no drive on write", oe_cnt, o0);
    end
    // R5 read sweep
    for (int r = 0; r < 32; r++) begin
      o0 = oe_cnt;
      rd_frame(phy_addr, 5'(r), rd);
      chk("R5 read data", {16'd0, rd}, {16'd0, pat(r)});
      chk("R7 drove during read", {31'd0, oe_cnt > o0}, 32'd1);
      chk("R7 released after read", {31'd0, mdio_oe}, 32'd0);
    end

    // R6 other address
    o0 = oe_cnt; w0 = we_cnt;
    rd_frame(phy_addr ^ 5'h01, 5'd3, rd);
    chk("R6 read unattached", {16'd0, rd}, 32'h0000FFFF);
    chk("R6 no drive", oe_cnt, o0);
    wr_frame(32, 1'b1, 2'b01, phy_addr ^ 5'h10, 5'd3, 16'h1234);
    chk("R6 no write", we_cnt, w0);

    // R2 short preamble, then longer preamble
    w0 = we_cnt;
    wr_frame(31, 1'b1, 2'b01, phy_addr, 5'd4, 16'hBEEF);
    chk("R2 short preamble ignored", we_cnt, w0);
    wr_frame(40, 1'b1, 2'b01, phy_addr, 5'd4, 16'hBEEF);
    chk("R2 long preamble accepted", we_cnt, w0 + 1);
    chk("R2 data", {16'd0, last_wd}, 32'h0000BEEF);

    // R10 back-to-back without preamble
    w0 = we_cnt;
    wr_frame(32, 1'b1, 2'b01, phy_addr, 5'd5, 16'h0F0F);
    wr_frame(0, 1'b1, 2'b01, phy_addr, 5'd6, 16'hF0F0);
    chk("R10 second frame ignored", we_cnt, w0 + 1);
    chk("R10 first frame reg", {27'd0, last_num}, 32'd5);

    // R8 bad second start bit
    w0 = we_cnt;
    wr_frame(32, 1'b0, 2'b01, phy_addr, 5'd7, 16'h5A5A);
    chk("R8 start_err set", {31'd0, start_err}, 32'd1);
    chk("R8 frame still decoded", we_cnt, w0 + 1);
    chk("R8 data", {16'd0, last_wd}, 32'h00005A5A);
    wr_frame(32, 1'b1, 2'b01, phy_addr, 5'd7, 16'hA5A5);
    chk("R8 start_err cleared", {31'd0, start_err}, 32'd0);

    // R9 unused opcodes
    w0 = we_cnt; o0 = oe_cnt;
    wr_frame(32, 1'b1, 2'b00, phy_addr, 5'd8, 16'hFFFF);
    wr_frame(32, 1'b1, 2'b11, phy_addr, 5'd8, 16'hFFFF);
    chk("R9 no write", we_cnt, w0);
    chk("R9 no drive", oe_cnt, o0);
    rd_frame(phy_addr, 5'd8, rd);
    chk("R9 register untouched", {16'd0, rd}, {16'd0, pat(8)});

    // R4 commit only after sixteenth bit
    w0 = we_cnt;
    preamble(32);
    header(1'b1, 2'b01, phy_addr, 5'd9);
    mbit(1'b1); mbit(1'b0);
    for (int i = 15; i >= 1; i--) mbit(1'(16'hC3A1 >> i));
    repeat (8) @(negedge clk);
    chk("R4 no strobe after 15 bits", we_cnt, w0);
    mbit(1'b1);
    repeat (4) @(negedge clk);
    chk("R4 strobe after 16th bit", we_cnt, w0 + 1);
    chk("R4 data after 16th bit", {16'd0, last_wd}, 32'h0000C3A1);

    // another PHY address
    phy_addr = 5'h1F;
    wr_frame(32, 1'b1, 2'b01, 5'h1F, 5'd31, 16'h8001);
    rd_frame(5'h1F, 5'd31, rd);
    chk("R5 read at address 31", {16'd0, rd}, 32'h00008001);
    rd_frame(5'h0B, 5'd31, rd);
    chk("R6 old address no longer answers", {16'd0, rd}, 32'h0000FFFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule